// File: doc/BRIEF.md
# Host Packet-Memory Access Pointer Unit

This block gives a host sequential byte access to an 8 KB packet memory. It keeps two independent 13-bit pointers, one for reads and one for writes. The host can load either pointer directly. Each accepted read or write request moves exactly one byte through a single-port memory interface, and then the pointer that was used moves on by one position.

A receive region is defined by an inclusive lower bound and an inclusive upper bound. The region may cross the top of memory, for example 0x1FF0 up to 0x0005. When the read pointer steps off the region's upper bound, it jumps back to the region's lower bound. The write pointer ignores the region and simply counts up modulo 8192.

The step rules are package functions and a parameterised pointer register. A second requester, such as a copy engine, can therefore reuse the same wrapping-read and linear-write behaviour.

Only one request is served per cycle, and a write wins over a read. A small two-state machine tracks the read response:
- `ST_IDLE` moves to `ST_RESP` when a read is accepted. Otherwise it stays in `ST_IDLE`.
- `ST_RESP` marks the cycle in which read data is valid. It returns to `ST_IDLE`, or stays in `ST_RESP` if another read is accepted in that cycle.

Top module: `buf_ptr_unit`

## Requirements
- R1: After reset both pointers read 0x0000 and `rd_valid` is 0.
- R2: An accepted write (`wr_ack`=1) drives `mem_we`=1, with `mem_addr` equal to the write pointer and `mem_wdata` equal to `wr_data`. The write pointer then advances by one.
- R3: The write pointer never applies the region wrap. Stepping from the region upper bound gives that bound plus one, and 0x1FFF steps to 0x0000.
- R4: An accepted read (`rd_ack`=1) presents the read pointer on `mem_addr` with `mem_we`=0. In the next cycle `rd_valid`=1 and `rd_data` carries the byte stored at that address.
- R5: A read from an address other than the region upper bound advances the read pointer by one modulo 8192, so 0x1FFF steps to 0x0000.
- R6: A read from the region upper bound sets the read pointer to the region lower bound. This holds both for regions that cross 0x1FFF to 0x0000 and for regions that do not.
- R7: When read and write requests arrive in the same cycle, only the write is acknowledged. The read is acknowledged in a later cycle once the write request is gone.
- R8: A pointer load in the same cycle as an access through that pointer takes effect first. The access uses the loaded address, and the pointer ends at the loaded address stepped once.
- R9: A pointer load with no access sets that pointer to the loaded address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_ld | input | 1 | Load the read pointer |
| rd_ld_addr | input | 13 | Value for the read pointer load |
| wr_ld | input | 1 | Load the write pointer |
| wr_ld_addr | input | 13 | Value for the write pointer load |
| rx_lo | input | 13 | Receive region lower bound (inclusive) |
| rx_hi | input | 13 | Receive region upper bound (inclusive) |
| rd_req | input | 1 | Read one byte |
| rd_ack | output | 1 | Read accepted this cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| wr_req | input | 1 | Write one byte |
| wr_data | input | 8 | Write data |
| wr_ack | output | 1 | Write accepted this cycle |
| rd_ptr_o | output | 13 | Current read pointer |
| wr_ptr_o | output | 13 | Current write pointer |
| mem_addr | output | 13 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |

## Verification
The hardest case is a read stepping off the region's upper bound when the region crosses the top of memory. Reaching it needs the bounds set to straddle 0x1FFF, the read pointer loaded just below the upper bound, and back-to-back reads across it. Before that, the bench fills the memory around the boundary through writes that pass the same upper bound without wrapping.

A scoreboard queue holds the byte expected for each accepted read. It is compared when `rd_valid` rises, so the wrapped address is confirmed through the returned data as well as through the pointer.

// File: rtl/buf_ptr_pkg.sv
package buf_ptr_pkg;
    parameter int unsigned BUF_AW = 13;
    typedef logic [BUF_AW-1:0] addr_t;

    typedef enum logic {ST_IDLE, ST_RESP} rd_state_e;

    // Region-aware step: upper bound jumps to lower bound, else +1 modulo size
    function automatic addr_t step_wrap(addr_t a, addr_t lo, addr_t hi);
        return (a == hi) ? lo : addr_t'(a + 1'b1);
    endfunction

    // Linear step, modulo size only
    function automatic addr_t step_lin(addr_t a);
        return addr_t'(a + 1'b1);
    endfunction
endpackage

// File: rtl/buf_ptr_reg.sv
module buf_ptr_reg
    import buf_ptr_pkg::*;
#(
    parameter bit WRAP = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld,
    input  addr_t ld_addr,
    input  logic  adv,
    input  addr_t lo,
    input  addr_t hi,
    output addr_t cur,
    output addr_t ptr
);
    addr_t ptr_q;
    addr_t nxt;

    assign cur = ld ? ld_addr : ptr_q;
    assign ptr = ptr_q;

    generate
        if (WRAP) begin : g_wrap
            assign nxt = step_wrap(cur, lo, hi);

            // R6
            wrap_to_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (adv && cur == hi) |=> (ptr == $past(lo)));
            // R5
            lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (adv && cur != hi) |=> (ptr == addr_t'($past(cur) + 1'b1)));
        end else begin : g_lin
            logic unused_bounds;
            assign unused_bounds = ^{lo, hi};
            assign nxt = step_lin(cur);

            // R3
            no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                adv |=> (ptr == addr_t'($past(cur) + 1'b1)));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)   ptr_q <= '0;
        else if (adv) ptr_q <= nxt;
        else if (ld)  ptr_q <= ld_addr;
    end

    // R9
    load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !adv) |=> (ptr == $past(ld_addr)));
endmodule

// File: rtl/buf_ptr_arb.sv
module buf_ptr_arb
    import buf_ptr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    output logic rd_ack,
    output logic wr_ack,
    output logic rd_valid
);
    rd_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_ack   = wr_req;
        rd_ack   = rd_req && !wr_req;
        rd_valid = 1'b0;
        state_d  = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = rd_ack ? ST_RESP : ST_IDLE;
            ST_RESP: begin
                rd_valid = 1'b1;
                state_d  = rd_ack ? ST_RESP : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R7
    wr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_req) |-> (wr_ack && !rd_ack));
    // R4
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> rd_valid);
    // R4
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ack |=> !rd_valid);
endmodule

// File: rtl/buf_ptr_unit.sv
module buf_ptr_unit
    import buf_ptr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ld,
    input  logic [BUF_AW-1:0] rd_ld_addr,
    input  logic              wr_ld,
    input  logic [BUF_AW-1:0] wr_ld_addr,
    input  logic [BUF_AW-1:0] rx_lo,
    input  logic [BUF_AW-1:0] rx_hi,
    input  logic              rd_req,
    output logic              rd_ack,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ack,
    output logic [BUF_AW-1:0] rd_ptr_o,
    output logic [BUF_AW-1:0] wr_ptr_o,
    output logic [BUF_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    addr_t rd_cur, wr_cur;

    buf_ptr_arb u_arb (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .rd_ack(rd_ack), .wr_ack(wr_ack), .rd_valid(rd_valid)
    );

    buf_ptr_reg #(.WRAP(1'b1)) u_rd_ptr (
        .clk(clk), .rst_n(rst_n), .ld(rd_ld), .ld_addr(rd_ld_addr),
        .adv(rd_ack), .lo(rx_lo), .hi(rx_hi), .cur(rd_cur), .ptr(rd_ptr_o)
    );

    buf_ptr_reg #(.WRAP(1'b0)) u_wr_ptr (
        .clk(clk), .rst_n(rst_n), .ld(wr_ld), .ld_addr(wr_ld_addr),
        .adv(wr_ack), .lo(rx_lo), .hi(rx_hi), .cur(wr_cur), .ptr(wr_ptr_o)
    );

    assign mem_addr  = wr_ack ? wr_cur : rd_cur;
    assign mem_we    = wr_ack;
    assign mem_wdata = wr_data;
    assign rd_data   = mem_rdata;

    // R2
    wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && !wr_ld) |-> (mem_addr == wr_ptr_o && mem_we));
    // R8
    ld_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && rd_ld) |-> (mem_addr == rd_ld_addr));
    // R4
    rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !rd_ld) |-> (mem_addr == rd_ptr_o && !mem_we));
endmodule

// File: tb/buf_ptr_unit_bench.sv
`timescale 1ns/1ps
module buf_ptr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_ld = 0, wr_ld = 0, rd_req = 0, wr_req = 0;
    logic [12:0] rd_ld_addr = 0, wr_ld_addr = 0, rx_lo = 0, rx_hi = 0;
    logic [7:0]  wr_data = 0;
    logic        rd_ack, rd_valid, wr_ack, mem_we;
    logic [7:0]  rd_data, mem_wdata;
    logic [7:0]  mem_rdata = 0;
    logic [12:0] rd_ptr_o, wr_ptr_o, mem_addr;

    logic [7:0]  mem [0:8191];
    logic [7:0]  shadow [0:8191];
    logic [7:0]  sb_q [$];
    logic [12:0] exp_rd, exp_wr;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    buf_ptr_unit u_buf_ptr_unit (
        .clk(clk), .rst_n(rst_n), .rd_ld(rd_ld), .rd_ld_addr(rd_ld_addr),
        .wr_ld(wr_ld), .wr_ld_addr(wr_ld_addr), .rx_lo(rx_lo), .rx_hi(rx_hi),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_req(wr_req), .wr_data(wr_data), .wr_ack(wr_ack),
        .rd_ptr_o(rd_ptr_o), .wr_ptr_o(wr_ptr_o), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [12:0] rd_step(logic [12:0] a);
        return (a == rx_hi) ? rx_lo : a + 13'd1;
    endfunction

    // Monitor: pop expected read bytes as responses appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb_q.size() == 0) chk(0, "R4 unexpected rd_valid", 1, 0);
            else begin
                logic [7:0] e;
                e = sb_q.pop_front();
                chk(rd_data == e, "R4 read data", rd_data, e);
            end
        end
    end

    // Called at posedge+1; leaves at next posedge+1 with request dropped
    task automatic do_write(input logic [7:0] d, input bit ld, input logic [12:0] la, input string req);
        wr_req = 1; wr_data = d; wr_ld = ld; wr_ld_addr = la;
        if (ld) exp_wr = la;
        @(negedge clk);
        chk(wr_ack && mem_we && mem_addr == exp_wr && mem_wdata == d, req, mem_addr, exp_wr);
        shadow[exp_wr] = d;
        exp_wr = exp_wr + 13'd1;
        @(posedge clk); #1;
        wr_req = 0; wr_ld = 0;
        chk(wr_ptr_o == exp_wr, req, wr_ptr_o, exp_wr);
    endtask

    task automatic do_read(input bit ld, input logic [12:0] la, input string req);
        rd_req = 1; rd_ld = ld; rd_ld_addr = la;
        if (ld) exp_rd = la;
        @(negedge clk);
        chk(rd_ack && !mem_we && mem_addr == exp_rd, req, mem_addr, exp_rd);
        sb_q.push_back(shadow[exp_rd]);
        exp_rd = rd_step(exp_rd);
        @(posedge clk); #1;
        rd_req = 0; rd_ld = 0;
        chk(rd_ptr_o == exp_rd, req, rd_ptr_o, exp_rd);
    endtask

    task automatic load_rd(input logic [12:0] a);
        rd_ld = 1; rd_ld_addr = a;
        @(posedge clk); #1;
        rd_ld = 0; exp_rd = a;
        chk(rd_ptr_o == a, "R9 read load", rd_ptr_o, a);
    endtask

    task automatic load_wr(input logic [12:0] a);
        wr_ld = 1; wr_ld_addr = a;
        @(posedge clk); #1;
        wr_ld = 0; exp_wr = a;
        chk(wr_ptr_o == a, "R9 write load", wr_ptr_o, a);
    endtask

    initial begin
        for (int i = 0; i < 8192; i++) begin
            mem[i] = 8'(i ^ (i >> 5));
            shadow[i] = 8'(i ^ (i >> 5));
        end
        exp_rd = 0; exp_wr = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(rd_ptr_o == 0 && wr_ptr_o == 0 && !rd_valid, "R1 reset", rd_ptr_o, 0);
        @(posedge clk); #1;

        // R3: straddling region, writes pass the upper bound linearly
        rx_lo = 13'h1FF0; rx_hi = 13'h0005;
        load_wr(13'h1FFE);
        do_write(8'hA1, 0, 0, "R2 write");
        do_write(8'hA2, 0, 0, "R3 write 1FFF->0");
        do_write(8'hA3, 0, 0, "R2 write");
        load_wr(13'h0004);
        do_write(8'hB4, 0, 0, "R2 write");
        do_write(8'hB5, 0, 0, "R3 write past upper bound");
        do_write(8'hB6, 0, 0, "R3 write linear");
        load_wr(13'h1FF0);
        do_write(8'hC0, 0, 0, "R2 write");

        // R6: straddling region read wrap
        load_rd(13'h0003);
        do_read(0, 0, "R4 read");
        do_read(0, 0, "R5 read step");
        do_read(0, 0, "R6 wrap straddle to lo");
        do_read(0, 0, "R5 read after wrap");

        // R6: plain region
        rx_lo = 13'h0100; rx_hi = 13'h01FF;
        load_rd(13'h01FE);
        do_read(0, 0, "R5 read");
        do_read(0, 0, "R6 wrap plain to lo");
        do_read(0, 0, "R5 read");

        // R5: 0x1FFF outside region steps to 0
        load_rd(13'h1FFE);
        do_read(0, 0, "R5 read");
        do_read(0, 0, "R5 read 1FFF->0");
        do_read(0, 0, "R5 read");

        // R7: simultaneous requests
        rd_req = 1; wr_req = 1; wr_data = 8'h5A;
        @(negedge clk);
        chk(wr_ack && !rd_ack, "R7 write first", {wr_ack, rd_ack}, 2);
        chk(mem_addr == exp_wr, "R7 write address", mem_addr, exp_wr);
        shadow[exp_wr] = 8'h5A; exp_wr = exp_wr + 13'd1;
        @(posedge clk); #1;
        wr_req = 0;
        chk(rd_ptr_o == exp_rd, "R7 read held", rd_ptr_o, exp_rd);
        @(negedge clk);
        chk(rd_ack && mem_addr == exp_rd, "R7 read later", mem_addr, exp_rd);
        sb_q.push_back(shadow[exp_rd]);
        exp_rd = rd_step(exp_rd);
        @(posedge clk); #1;
        rd_req = 0;
        chk(rd_ptr_o == exp_rd, "R7 read step", rd_ptr_o, exp_rd);

        // R8: load with access
        do_read(1, 13'h0010, "R8 read load priority");
        do_write(8'h77, 1, 13'h0300, "R8 write load priority");
        do_read(1, 13'h0300, "R8 read back");
        do_read(1, 13'h01FF, "R8 load at upper bound wraps");

        repeat (3) @(posedge clk);
        #1;
        chk(sb_q.size() == 0, "R4 all reads answered", sb_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule